// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This block is a lane-parallel integer datapath for wide-precision arithmetic. Each 64-bit lane receives an accumulator word and two multiplicand words. It takes the low 52 bits of each multiplicand as an unsigned number and forms their 104-bit product. A mode input then picks either the upper or the lower 52-bit half of that product. The picked half is zero-extended and added to the 64-bit accumulator of the same lane. Big-number code uses the two modes in pairs: the low half and the high half of each partial product are accumulated into separate limbs.

The lane count is a parameter and may be 2 or 4. The result bus is always as wide as the largest vector. Lanes above the active count read as zero. Work moves through a fixed three-stage pipeline: partial products, then reduction and half selection, then the accumulate. A valid flag travels alongside the data. The mode is captured with the operands, so any cycle may start a new operation in either mode.

Top module: `mac52_unit`

## Requirements
- R1: Bits [63:52] of each multiplicand lane have no effect on the result.
- R2: With `hi_mode_i`=1, a lane result is acc + zero-extended product bits [103:52], where the product is the unsigned product of the two 52-bit fields.
- R3: With `hi_mode_i`=0, a lane result is acc + zero-extended product bits [51:0].
- R4: The 64-bit accumulate wraps modulo 2^64, with no saturation and no carry out.
- R5: Lanes are independent. Lane k occupies bits [64k+63:64k] of every vector port, and no lane's data affects another lane's result.
- R6: `NUM_LANES` is 2 or 4. Bits of `result_o` at and above `NUM_LANES`*64 are always zero.
- R7: `valid_o` is `valid_i` delayed by exactly 3 clock edges. `result_o` holds that operation's result while `valid_o` is high.
- R8: The mode is sampled with the operands on the `valid_i` cycle, so back-to-back operations may use different modes.
- R9: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0. An operation still in flight when reset is asserted produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| hi_mode_i | input | 1 | 1: add product bits [103:52]; 0: add bits [51:0] |
| acc_i | input | NUM_LANES*64 | Accumulator lanes |
| mul_a_i | input | NUM_LANES*64 | First multiplicand lanes (bits [51:0] of each lane used) |
| mul_b_i | input | NUM_LANES*64 | Second multiplicand lanes (bits [51:0] of each lane used) |
| valid_o | output | 1 | Result valid |
| result_o | output | OUT_W (256) | Result lanes; bits above NUM_LANES*64 are zero |

## Verification
The operand patterns are chosen so that each one isolates a single effect. Operands of 1 and small values keep the whole product in the low half, which separates the two modes. Fully set 52-bit fields place ones in both halves and exercise every carry of the reduction. Set bits in [63:52] of the multiplicands must leave the result unchanged, which shows the fields are truncated. An accumulator close to 2^64 shows that the sum wraps. Each lane gets its own data, so any crossing between lanes shows up. Operations issued back to back in alternating modes show that the mode is sampled per operation. A batch of random vectors covers the remaining combinations.

// File: rtl/mac52_pkg.sv
package mac52_pkg;
  localparam int unsigned LANE_W  = 64;
  localparam int unsigned FIELD_W = 52;
  localparam int unsigned PROD_W  = 2 * FIELD_W;
  localparam int unsigned MAX_W   = 256;
  localparam int unsigned LAT     = 3;

  typedef logic [LANE_W-1:0]  lane_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [PROD_W-1:0]  prod_t;
endpackage

// File: rtl/mac52_valid_pipe.sv
module mac52_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] stage_o
);
  logic [DEPTH-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= {v_q[DEPTH-2:0], valid_i};
  end

  assign stage_o = v_q;
endmodule

// File: rtl/mac52_lane.sv
module mac52_lane
  import mac52_pkg::*;
#(
  parameter int unsigned SPLIT_W = FIELD_W / 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en1_i,
  input  logic  en2_i,
  input  logic  en3_i,
  input  logic  hi_mode_i,
  input  lane_t acc_i,
  input  lane_t mul_a_i,
  input  lane_t mul_b_i,
  output lane_t res_o
);
  localparam int unsigned BHI_W = FIELD_W - SPLIT_W;
  localparam int unsigned PLO_W = FIELD_W + SPLIT_W;
  localparam int unsigned PHI_W = FIELD_W + BHI_W;

  // stage 1: two partial products over a split second operand
  field_t               a_f;
  logic [SPLIT_W-1:0]   b_lo;
  logic [BHI_W-1:0]     b_hi;
  logic [PLO_W-1:0]     pp_lo_q;
  logic [PHI_W-1:0]     pp_hi_q;
  lane_t                acc1_q;
  logic                 hi1_q;

  assign a_f  = mul_a_i[FIELD_W-1:0];
  assign b_lo = mul_b_i[SPLIT_W-1:0];
  assign b_hi = mul_b_i[FIELD_W-1:SPLIT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
      acc1_q  <= '0;
      hi1_q   <= 1'b0;
    end else if (en1_i) begin
      pp_lo_q <= PLO_W'(a_f) * PLO_W'(b_lo);
      pp_hi_q <= PHI_W'(a_f) * PHI_W'(b_hi);
      acc1_q  <= acc_i;
      hi1_q   <= hi_mode_i;
    end
  end

  // stage 2: reduce and pick half
  prod_t  prod;
  field_t sel;
  field_t sel2_q;
  lane_t  acc2_q;

  assign prod = PROD_W'(pp_lo_q) + (PROD_W'(pp_hi_q) << SPLIT_W);
  assign sel  = hi1_q ? prod[PROD_W-1:FIELD_W] : prod[FIELD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel2_q <= '0;
      acc2_q <= '0;
    end else if (en2_i) begin
      sel2_q <= sel;
      acc2_q <= acc1_q;
    end
  end

  // stage 3: accumulate, wraps mod 2^64
  lane_t res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (en3_i) res_q <= acc2_q + LANE_W'(sel2_q);
  end

  assign res_o = res_q;
endmodule

// File: rtl/mac52_unit.sv
module mac52_unit
  import mac52_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned OUT_W     = MAX_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          hi_mode_i,
  input  logic [NUM_LANES*LANE_W-1:0]   acc_i,
  input  logic [NUM_LANES*LANE_W-1:0]   mul_a_i,
  input  logic [NUM_LANES*LANE_W-1:0]   mul_b_i,
  output logic                          valid_o,
  output logic [OUT_W-1:0]              result_o
);
  localparam int unsigned ACT_W = NUM_LANES * LANE_W;

  logic [LAT-1:0]   vstage;
  logic [ACT_W-1:0] res_act;

  mac52_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .stage_o (vstage)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    mac52_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en1_i     (valid_i),
      .en2_i     (vstage[0]),
      .en3_i     (vstage[1]),
      .hi_mode_i (hi_mode_i),
      .acc_i     (acc_i[l*LANE_W +: LANE_W]),
      .mul_a_i   (mul_a_i[l*LANE_W +: LANE_W]),
      .mul_b_i   (mul_b_i[l*LANE_W +: LANE_W]),
      .res_o     (res_act[l*LANE_W +: LANE_W])
    );
  end

  if (OUT_W > ACT_W) begin : g_pad
    assign result_o = {{(OUT_W-ACT_W){1'b0}}, res_act};
  end else begin : g_nopad
    assign result_o = res_act[OUT_W-1:0];
  end

  assign valid_o = vstage[LAT-1];
endmodule

// File: rtl/mac52_unit_chk.sv
module mac52_unit_chk
  import mac52_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned OUT_W     = MAX_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic                        hi_mode_i,
  input logic [NUM_LANES*LANE_W-1:0] acc_i,
  input logic [NUM_LANES*LANE_W-1:0] mul_a_i,
  input logic [NUM_LANES*LANE_W-1:0] mul_b_i,
  input logic                        valid_o,
  input logic [OUT_W-1:0]            result_o
);
  localparam int unsigned ACT_W = NUM_LANES * LANE_W;

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  function automatic lane_t ref_lane(lane_t acc, lane_t a, lane_t b, logic hi);
    prod_t p;
    p = PROD_W'(a[FIELD_W-1:0]) * PROD_W'(b[FIELD_W-1:0]);
    return acc + (hi ? LANE_W'(p[PROD_W-1:FIELD_W]) : LANE_W'(p[FIELD_W-1:0]));
  endfunction

  // R7: valid delayed by three edges
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  // R9: reset holds outputs clear
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert (!valid_o && result_o == '0);
    end
  end

  // R6: lanes above the active count stay zero
  if (OUT_W > ACT_W) begin : g_pad_chk
    a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_o[OUT_W-1:ACT_W] == '0);
  end

  // R2 R3 R4 R5 R8: per-lane function of the operands three edges back
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
    a_r2_lane_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd3 && valid_o) |->
        result_o[l*LANE_W +: LANE_W] == ref_lane($past(acc_i[l*LANE_W +: LANE_W], 3),
                                                 $past(mul_a_i[l*LANE_W +: LANE_W], 3),
                                                 $past(mul_b_i[l*LANE_W +: LANE_W], 3),
                                                 $past(hi_mode_i, 3)));
  end

  // R7: result is steady while no new result arrives
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && !valid_o && !$past(valid_o)) |-> $stable(result_o));
endmodule

bind mac52_unit mac52_unit_chk #(.NUM_LANES(NUM_LANES), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/mac52_unit_tb.sv
module mac52_unit_tb;
  import mac52_pkg::*;

  localparam int unsigned NL    = 2;
  localparam int unsigned OW    = MAX_W;
  localparam int unsigned ACT_W = NL * LANE_W;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             valid_i;
  logic             hi_mode_i;
  logic [ACT_W-1:0] acc_i, mul_a_i, mul_b_i;
  logic             valid_o;
  logic [OW-1:0]    result_o;

  always #5 clk_i = ~clk_i;

  mac52_unit #(.NUM_LANES(NL), .OUT_W(OW)) u_dut (.*);

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [ACT_W-1:0] exp_q[$];
  int               due_q[$];
  string            tag_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic lane_t model(lane_t acc, lane_t a, lane_t b, logic hi);
    logic [PROD_W-1:0] p;
    logic [63:0] a52, b52;
    a52 = a & 64'h000F_FFFF_FFFF_FFFF;
    b52 = b & 64'h000F_FFFF_FFFF_FFFF;
    p = PROD_W'(a52) * PROD_W'(b52);
    return acc + (hi ? {12'h0, p[103:52]} : {12'h0, p[51:0]});
  endfunction

  task automatic fail(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    n_bad++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  // scoreboard: compares every valid_o against issued work
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          n_vec++;
          fail("R7 spurious valid", 1, 0);
        end else begin
          n_vec++;
          if (cyc != due_q[0]) fail({"R7 latency ", tag_q[0]}, OW'(cyc), OW'(due_q[0]));
          n_vec++;
          if (result_o != OW'(exp_q[0])) fail(tag_q[0], result_o, OW'(exp_q[0]));
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
        n_vec++;
        if (result_o[OW-1:ACT_W] != '0) fail("R6 upper bits", result_o, OW'(result_o[ACT_W-1:0]));
      end else if (due_q.size() != 0 && cyc >= due_q[0]) begin
        n_vec++;
        fail({"R7 missing ", tag_q[0]}, 0, 1);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  task automatic issue(logic [ACT_W-1:0] acc, logic [ACT_W-1:0] a, logic [ACT_W-1:0] b,
                       logic hi, string tag);
    logic [ACT_W-1:0] e;
    @(negedge clk_i);
    valid_i = 1'b1; hi_mode_i = hi; acc_i = acc; mul_a_i = a; mul_b_i = b;
    for (int l = 0; l < int'(NL); l++)
      e[l*64 +: 64] = model(acc[l*64 +: 64], a[l*64 +: 64], b[l*64 +: 64], hi);
    exp_q.push_back(e); due_q.push_back(cyc + 3); tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk_i);
    valid_i = 1'b0; acc_i = '1; mul_a_i = '1; mul_b_i = '1; hi_mode_i = 1'b1;
    repeat (6) @(negedge clk_i);
    n_vec++;
    if (exp_q.size() != 0) fail("R7 drain", OW'(exp_q.size()), 0);
  endtask

  task automatic t_reset();
    n_vec++;
    if (valid_o !== 1'b0 || result_o !== '0) fail("R9 reset state", result_o, 0);
  endtask

  task automatic t_modes();
    issue({64'd10, 64'd5}, {64'd3, 64'd7}, {64'd4, 64'd6}, 1'b0, "R3 small lo");
    issue({64'd10, 64'd5}, {64'd3, 64'd7}, {64'd4, 64'd6}, 1'b1, "R2 small hi");
    issue({64'd0, 64'd0}, {64'h1, 64'h0010_0000_0000}, {64'h0010_0000_0000, 64'h0010_0000_0000},
          1'b1, "R2 hi boundary");
    drain();
  endtask

  task automatic t_all_ones();
    issue('0, {2{64'h000F_FFFF_FFFF_FFFF}}, {2{64'h000F_FFFF_FFFF_FFFF}}, 1'b1, "R2 ones hi");
    issue('0, {2{64'h000F_FFFF_FFFF_FFFF}}, {2{64'h000F_FFFF_FFFF_FFFF}}, 1'b0, "R3 ones lo");
    drain();
  endtask

  task automatic t_upper_ignored();
    issue({64'd1, 64'd2}, {64'hFFF0_0000_0000_0003, 64'hABC0_0000_0000_0009},
          {64'h5550_0000_0000_0005, 64'hFFF0_0000_0000_0002}, 1'b0, "R1 junk upper lo");
    issue({64'd1, 64'd2}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
          {64'hFFF0_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b1, "R1 junk upper hi");
    drain();
  endtask

  task automatic t_wrap();
    issue({64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0}, {64'd1, 64'd4},
          {64'd1, 64'd5}, 1'b0, "R4 wrap lo");
    issue({2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h000F_FFFF_FFFF_FFFF}},
          {2{64'h000F_FFFF_FFFF_FFFF}}, 1'b1, "R4 wrap hi");
    drain();
  endtask

  task automatic t_lanes();
    issue({64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, {64'h000F_FFFF_FFFF_FFFF, 64'd0},
          {64'h000F_FFFF_FFFF_FFFF, 64'd0}, 1'b0, "R5 lane1 busy lane0 zero");
    issue({64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd0, 64'h000F_FFFF_FFFF_FFFF},
          {64'd0, 64'h000F_FFFF_FFFF_FFFF}, 1'b1, "R5 lane0 busy lane1 zero");
    drain();
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 8; i++)
      issue({64'(i) * 64'h1111, 64'(i)}, {2{64'h000A_BCDE_F012_3456 + 64'(i)}},
            {2{64'h0009_8765_4321_0FED - 64'(i)}}, i[0], "R8 alternating mode");
    drain();
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++)
      issue({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 1'($urandom), "R2 R3 random");
    drain();
  endtask

  task automatic t_mid_reset();
    issue({64'd7, 64'd7}, {64'd1, 64'd1}, {64'd1, 64'd1}, 1'b0, "R9 flushed");
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    @(negedge clk_i);
    n_vec++;
    if (valid_o !== 1'b0 || result_o !== '0) fail("R9 mid reset", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    n_vec++;
    if (valid_o !== 1'b0) fail("R9 in-flight dropped", OW'(valid_o), 0);
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; hi_mode_i = 1'b0;
    acc_i = '0; mul_a_i = '0; mul_b_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_modes();
    t_all_ones();
    t_upper_ignored();
    t_wrap();
    t_lanes();
    t_b2b();
    t_random();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule